// File: doc/BRIEF.md
# Flash Completion Polling Controller

This block runs on the host side of a parallel flash device. It takes one program or erase request at a time and issues the command as a single bus write. It then watches the device until the operation has finished and reports the outcome as a one-cycle `done` or `error` pulse.

Three ways of waiting are available, and each request chooses one:
- **Ready/busy mode** watches a dedicated ready line from the device.
- **Data polling** re-reads the target location and compares bit 7.
- **Toggle polling** re-reads the location until bit 6 stops changing.

A status read can land in the same instant that the device finishes. The block therefore does not act on a single final word that looks wrong: it reads the location twice more before it accepts or rejects the result. Each request also carries a poll limit, and running past it ends the operation with an error.

After reset the block first makes sure the device is usable. If the device is ready, the block waits a fixed recovery time. If the device is busy, it waits for the ready line instead.

States:
- `ST_RECOVER`: recovery count after reset.
- `ST_RST_BUSY`: device found busy after reset.
- `ST_IDLE`: accepting requests.
- `ST_CMD`: command write.
- `ST_HW_WAIT`: watching the ready line.
- `ST_POLL`: status reads.
- `ST_CONF1` and `ST_CONF2`: the two confirming reads.
- `ST_OK` and `ST_FAIL`: result pulses.

Transitions:
- `ST_RECOVER` goes to `ST_IDLE` when the count completes, or to `ST_RST_BUSY` when the ready line is low.
- `ST_RST_BUSY` goes to `ST_IDLE` when the ready line rises.
- `ST_IDLE` goes to `ST_CMD` on a request, or straight to `ST_FAIL` on the reserved mode.
- `ST_CMD` goes to `ST_HW_WAIT` or to `ST_POLL`, depending on the mode.
- `ST_HW_WAIT` goes to `ST_OK` when the device is ready, or to `ST_FAIL` on timeout.
- `ST_POLL` goes to `ST_OK` on an exact completion, to `ST_CONF1` on a completion whose word mismatches, or to `ST_FAIL` on timeout.
- `ST_CONF1` goes to `ST_CONF2`.
- `ST_CONF2` goes to `ST_OK` or to `ST_FAIL`.
- `ST_OK` and `ST_FAIL` return to `ST_IDLE`.

Top module: `flash_poll_ctrl`

## Requirements
- R1: After reset is released with `flash_ready` high, `req_ready` rises exactly RECOVERY_CYC clock edges later, with no bus activity before it.
- R2: If `flash_ready` is low after reset, `req_ready` stays low while it is low and rises one edge after `flash_ready` goes high, with no further recovery wait.
- R3: `req_ready` is high only in the idle state, and a request is taken only there. The cycle after acceptance carries exactly one `bus_wr` to `req_addr`, with data `req_data` for a program (`req_erase`=0) or ERASE_CMD for an erase. Requests raised during an operation are ignored.
- R4: In ready/busy mode (`req_mode`=2'b00) the block makes no reads. `done` pulses in the cycle after the first edge at which `flash_ready` is sampled high.
- R5: In data-poll mode (`req_mode`=2'b01) for a program, a read is a completion when its bit 7 equals bit 7 of `req_data`.
- R6: In data-poll mode for an erase, a read is a completion when its bit 7 is 1, and the expected word is all ones.
- R7: In toggle mode (`req_mode`=2'b10), the first read is only a reference. A later read is a completion when its bit 6 equals bit 6 of the previous read.
- R8: A completion whose full word equals the expected word gives `done` at once. A completion whose word differs triggers exactly two further reads: `done` if both equal the expected word, `error` otherwise.
- R9: Each busy observation counts: a busy read, or a cycle in ready/busy mode with `flash_ready` low. The observation that brings the count to `poll_limit` gives `error`, and confirmation reads are not counted.
- R10: `req_mode`=2'b11 is rejected. `error` pulses in the cycle after acceptance, with no bus access.
- R11: `done` and `error` are single-cycle pulses, never high together, and `req_ready` is high in the cycle after either.
- R12: `req_mode`, `poll_limit`, the address and the data are captured at acceptance. Changing these inputs during an operation has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request strobe |
| req_ready | output | 1 | High in the idle state |
| req_erase | input | 1 | 1 = erase, 0 = program |
| req_mode | input | 2 | 00 ready/busy, 01 data poll, 10 toggle, 11 reserved |
| req_addr | input | AW | Target address |
| req_data | input | DW | Program data (expected word) |
| poll_limit | input | CW | Busy observations allowed |
| flash_ready | input | 1 | Device ready line, high = ready |
| bus_wr | output | 1 | Command write strobe |
| bus_rd | output | 1 | Status read strobe, data sampled on the same edge |
| bus_addr | output | AW | Bus address |
| bus_wdata | output | DW | Write data |
| bus_rdata | input | DW | Read data |
| done | output | 1 | Success pulse |
| error | output | 1 | Rejection, timeout or reserved-mode pulse |

## Verification
The bench builds the block with AW=12, DW=8, CW=8, RECOVERY_CYC=6 and ERASE_CMD=8'h30. The short recovery count makes the exact edge at which `req_ready` rises after reset easy to check. The 8-bit limit lets small values such as 3 and 5 place each timeout at a known read count or latency. A scripted read model returns a chosen word for each successive read, so that every completion rule and both outcomes of the double confirmation can be driven one read at a time.

// File: rtl/flash_poll_pkg.sv
package flash_poll_pkg;

    localparam int POLL_BIT   = 7;
    localparam int TOGGLE_BIT = 6;

    typedef enum logic [1:0] {
        MODE_RDY    = 2'b00,
        MODE_DATA   = 2'b01,
        MODE_TOGGLE = 2'b10,
        MODE_RSVD   = 2'b11
    } wait_mode_e;

    typedef enum logic [3:0] {
        ST_RECOVER,
        ST_RST_BUSY,
        ST_IDLE,
        ST_CMD,
        ST_HW_WAIT,
        ST_POLL,
        ST_CONF1,
        ST_CONF2,
        ST_OK,
        ST_FAIL
    } fpc_state_e;

endpackage

// File: rtl/fpc_status_judge.sv
module fpc_status_judge
    import flash_poll_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic          toggle_mode,
    input  logic          have_prev,
    input  logic          prev_bit,
    input  logic [DW-1:0] rdata,
    input  logic [DW-1:0] exp_word,
    output logic          complete,
    output logic          exact
);
    // exp_word is all ones for erase, so one bit-7 compare covers both cases
    always_comb begin
        if (toggle_mode) begin
            complete = have_prev && (rdata[TOGGLE_BIT] == prev_bit);
        end else begin
            complete = (rdata[POLL_BIT] == exp_word[POLL_BIT]);
        end
        exact = (rdata == exp_word);
    end
endmodule

// File: rtl/fpc_poll_counter.sv
module fpc_poll_counter #(
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          inc,
    input  logic [CW-1:0] limit,
    output logic          hit
);
    logic [CW-1:0] cnt_q;

    // hit: the observation counted now reaches the limit
    assign hit = ({1'b0, cnt_q} + {{CW{1'b0}}, 1'b1}) >= {1'b0, limit};

    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            cnt_q <= '0;
        end else if (inc && !hit) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/flash_poll_ctrl.sv
module flash_poll_ctrl
    import flash_poll_pkg::*;
#(
    parameter int          AW           = 16,
    parameter int          DW           = 8,
    parameter int          CW           = 16,
    parameter int          RECOVERY_CYC = 8,
    parameter logic [DW-1:0] ERASE_CMD  = 8'h30
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    output logic          req_ready,
    input  logic          req_erase,
    input  logic [1:0]    req_mode,
    input  logic [AW-1:0] req_addr,
    input  logic [DW-1:0] req_data,
    input  logic [CW-1:0] poll_limit,
    input  logic          flash_ready,
    output logic          bus_wr,
    output logic          bus_rd,
    output logic [AW-1:0] bus_addr,
    output logic [DW-1:0] bus_wdata,
    input  logic [DW-1:0] bus_rdata,
    output logic          done,
    output logic          error
);
    localparam logic [CW-1:0] REC_LIMIT = CW'(RECOVERY_CYC);

    fpc_state_e    st_q, st_d;
    wait_mode_e    mode_q;
    logic          erase_q;
    logic [AW-1:0] addr_q;
    logic [DW-1:0] exp_q;
    logic [CW-1:0] lim_q;
    logic          have_prev_q, prev6_q, conf_ok_q;

    logic          cnt_clr, cnt_inc, lim_rec, cnt_hit;
    logic          complete, exact;

    fpc_status_judge #(.DW(DW)) u_judge (
        .toggle_mode (mode_q == MODE_TOGGLE),
        .have_prev   (have_prev_q),
        .prev_bit    (prev6_q),
        .rdata       (bus_rdata),
        .exp_word    (exp_q),
        .complete    (complete),
        .exact       (exact)
    );

    fpc_poll_counter #(.CW(CW)) u_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (cnt_clr),
        .inc   (cnt_inc),
        .limit (lim_rec ? REC_LIMIT : lim_q),
        .hit   (cnt_hit)
    );

    // next state and counter control
    always_comb begin
        st_d    = st_q;
        cnt_clr = 1'b0;
        cnt_inc = 1'b0;
        lim_rec = 1'b0;
        unique case (st_q)
            ST_RECOVER: begin
                lim_rec = 1'b1;
                if (!flash_ready) begin
                    st_d = ST_RST_BUSY;
                end else begin
                    cnt_inc = 1'b1;
                    if (cnt_hit) st_d = ST_IDLE;
                end
            end
            ST_RST_BUSY: if (flash_ready) st_d = ST_IDLE;
            ST_IDLE: begin
                cnt_clr = 1'b1;
                if (req_valid) begin
                    st_d = (wait_mode_e'(req_mode) == MODE_RSVD) ? ST_FAIL : ST_CMD;
                end
            end
            ST_CMD: st_d = (mode_q == MODE_RDY) ? ST_HW_WAIT : ST_POLL;
            ST_HW_WAIT: begin
                if (flash_ready) begin
                    st_d = ST_OK;
                end else begin
                    cnt_inc = 1'b1;
                    if (cnt_hit) st_d = ST_FAIL;
                end
            end
            ST_POLL: begin
                if (complete) begin
                    st_d = exact ? ST_OK : ST_CONF1;
                end else if (mode_q == MODE_TOGGLE && !have_prev_q) begin
                    st_d = ST_POLL;
                end else begin
                    cnt_inc = 1'b1;
                    if (cnt_hit) st_d = ST_FAIL;
                end
            end
            ST_CONF1: st_d = ST_CONF2;
            ST_CONF2: st_d = (conf_ok_q && exact) ? ST_OK : ST_FAIL;
            ST_OK:    st_d = ST_IDLE;
            ST_FAIL:  st_d = ST_IDLE;
            default:  st_d = ST_IDLE;
        endcase
    end

    // state register and request capture
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q        <= ST_RECOVER;
            mode_q      <= MODE_RDY;
            erase_q     <= 1'b0;
            addr_q      <= '0;
            exp_q       <= '0;
            lim_q       <= '0;
            have_prev_q <= 1'b0;
            prev6_q     <= 1'b0;
            conf_ok_q   <= 1'b0;
        end else begin
            st_q <= st_d;
            if (st_q == ST_IDLE && req_valid) begin
                mode_q      <= wait_mode_e'(req_mode);
                erase_q     <= req_erase;
                addr_q      <= req_addr;
                exp_q       <= req_erase ? '1 : req_data;
                lim_q       <= poll_limit;
                have_prev_q <= 1'b0;
            end
            if (st_q == ST_POLL) begin
                have_prev_q <= 1'b1;
                prev6_q     <= bus_rdata[TOGGLE_BIT];
            end
            if (st_q == ST_CONF1) conf_ok_q <= exact;
        end
    end

    // outputs
    always_comb begin
        req_ready = (st_q == ST_IDLE);
        bus_wr    = (st_q == ST_CMD);
        bus_rd    = (st_q == ST_POLL) || (st_q == ST_CONF1) || (st_q == ST_CONF2);
        bus_addr  = addr_q;
        bus_wdata = erase_q ? ERASE_CMD : exp_q;
        done      = (st_q == ST_OK);
        error     = (st_q == ST_FAIL);
    end
endmodule

// File: rtl/fpc_checks.sv
module fpc_checks (
    input logic       clk,
    input logic       rst_n,
    input logic       req_valid,
    input logic       req_ready,
    input logic [1:0] req_mode,
    input logic       bus_rd,
    input logic       bus_wr,
    input logic       done,
    input logic       error
);
    AST_DONE_ERR_EXCL: assert property (@(posedge clk) disable iff (!rst_n) !(done && error)); // R11
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done); // R11
    AST_ERR_PULSE: assert property (@(posedge clk) disable iff (!rst_n) error |=> !error); // R11
    AST_END_TO_IDLE: assert property (@(posedge clk) disable iff (!rst_n) (done || error) |=> req_ready); // R11
    AST_ACCEPT_WRITES: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && req_mode != 2'b11) |=> (bus_wr && !req_ready)); // R3
    AST_RSVD_REJECT: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && req_mode == 2'b11) |=> (error && !bus_wr && !bus_rd)); // R10
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n) req_ready |-> !(bus_rd || bus_wr)); // R3
    AST_RD_WR_EXCL: assert property (@(posedge clk) disable iff (!rst_n) !(bus_rd && bus_wr)); // R3
endmodule

bind flash_poll_ctrl fpc_checks u_fpc_checks (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .req_mode  (req_mode),
    .bus_rd    (bus_rd),
    .bus_wr    (bus_wr),
    .done      (done),
    .error     (error)
);

// File: tb/test_flash_poll_ctrl.sv
module test_flash_poll_ctrl;
    localparam int AW = 12;
    localparam int DW = 8;
    localparam int CW = 8;
    localparam int REC = 6;
    localparam logic [7:0] ECMD = 8'h30;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0, req_erase = 1'b0;
    logic [1:0]    req_mode = 2'b00;
    logic [AW-1:0] req_addr = '0;
    logic [DW-1:0] req_data = '0;
    logic [CW-1:0] poll_limit = '0;
    logic          flash_ready = 1'b1;
    logic          req_ready, bus_wr, bus_rd, done, error;
    logic [AW-1:0] bus_addr;
    logic [DW-1:0] bus_wdata, bus_rdata;

    int n_chk = 0, n_fail = 0;

    logic [7:0]    script [8];
    logic [7:0]    rd_idx;
    logic [2:0]    sidx;
    logic          log_clr = 1'b0;
    int            wr_cnt;
    logic [AW-1:0] wr_addr;
    logic [DW-1:0] wr_data;

    int r_lat, r_reads;
    logic r_done, r_err;

    always #10 clk = ~clk; // 50 MHz

    flash_poll_ctrl #(.AW(AW), .DW(DW), .CW(CW), .RECOVERY_CYC(REC), .ERASE_CMD(ECMD)) i_flash_poll_ctrl (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_erase(req_erase), .req_mode(req_mode), .req_addr(req_addr), .req_data(req_data),
        .poll_limit(poll_limit), .flash_ready(flash_ready), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .done(done), .error(error)
    );

    // scripted device: successive reads return successive script words
    assign sidx = (rd_idx > 8'd7) ? 3'd7 : rd_idx[2:0];
    assign bus_rdata = script[sidx];

    always @(posedge clk) begin
        if (log_clr) begin
            rd_idx <= 8'd0;
            wr_cnt <= 0;
        end else begin
            if (bus_rd) rd_idx <= rd_idx + 8'd1;
            if (bus_wr) begin
                wr_cnt  <= wr_cnt + 1;
                wr_addr <= bus_addr;
                wr_data <= bus_wdata;
            end
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic set_script(input logic [63:0] p);
        for (int i = 0; i < 8; i++) script[i] = p[8*i +: 8];
    endtask

    task automatic do_reset(input logic rdy);
        flash_ready = rdy;
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        chk("R1 reset ready", int'(req_ready), 0);
        chk("R11 reset pulses", int'(done | error | bus_rd | bus_wr), 0);
        rst_n = 1'b1;
    endtask

    // launch one request; results in r_* variables
    task automatic run_op(input logic erase, input logic [1:0] mode, input logic [AW-1:0] addr,
                          input logic [DW-1:0] data, input logic [CW-1:0] lim,
                          input int rise_at, input bit scramble, input int hold_until);
        @(negedge clk);
        log_clr = 1'b1;
        @(negedge clk);
        log_clr = 1'b0;
        req_erase = erase; req_mode = mode; req_addr = addr; req_data = data; poll_limit = lim;
        req_valid = 1'b1;
        @(posedge clk);
        @(negedge clk);
        if (hold_until == 0) req_valid = 1'b0;
        if (scramble) begin
            req_mode = 2'b00; poll_limit = 8'd200; req_addr = ~addr; req_data = ~data;
        end
        r_lat = 0;
        while (!done && !error && r_lat < 300) begin
            if (r_lat == rise_at) flash_ready = 1'b1;
            if (r_lat == hold_until) req_valid = 1'b0;
            @(negedge clk);
            r_lat++;
        end
        req_valid = 1'b0;
        r_done = done; r_err = error; r_reads = int'(rd_idx);
        @(negedge clk);
        chk("R11 single pulse", int'(done | error), 0);
        chk("R11 back to idle", int'(req_ready), 1);
    endtask

    task automatic t_reset_idle;
        int n;
        do_reset(1'b1);
        n = 0;
        while (!req_ready && n < 50) begin
            @(negedge clk);
            n++;
            if (n < REC) chk("R1 no bus in recovery", int'(bus_rd | bus_wr), 0);
        end
        chk("R1 recovery edges", n, REC);
    endtask

    task automatic t_reset_busy;
        do_reset(1'b0);
        repeat (12) @(negedge clk);
        chk("R2 held while busy", int'(req_ready), 0);
        flash_ready = 1'b1;
        @(negedge clk);
        chk("R2 ready one edge later", int'(req_ready), 1);
    endtask

    task automatic t_hw_ok;
        flash_ready = 1'b0;
        run_op(1'b0, 2'b00, 12'h123, 8'h5A, 8'd20, 4, 1'b0, 0);
        chk("R4 done", int'(r_done), 1);
        chk("R4 latency", r_lat, 5);
        chk("R4 no reads", r_reads, 0);
        chk("R3 write addr", int'(wr_addr), 'h123);
        chk("R3 write data", int'(wr_data), 'h5A);
        chk("R3 one write", wr_cnt, 1);
    endtask

    task automatic t_hw_timeout;
        flash_ready = 1'b0;
        run_op(1'b0, 2'b00, 12'h010, 8'h00, 8'd5, 1000, 1'b0, 0);
        flash_ready = 1'b1;
        chk("R9 hw timeout error", int'(r_err), 1);
        chk("R9 hw timeout latency", r_lat, 6);
    endtask

    task automatic t_data_prog;
        set_script({8'hA5, 8'hA5, 8'hA5, 8'hA5, 8'hA5, 8'hA5, 8'h25, 8'h25});
        run_op(1'b0, 2'b01, 12'h456, 8'hA5, 8'd10, 1000, 1'b0, 0);
        chk("R5 done", int'(r_done), 1);
        chk("R5 reads", r_reads, 3);
    endtask

    task automatic t_data_erase;
        set_script({8'hFF, 8'hFF, 8'hFF, 8'hFF, 8'hFF, 8'hFF, 8'hFF, 8'h7F});
        run_op(1'b1, 2'b01, 12'h800, 8'h00, 8'd10, 1000, 1'b0, 0);
        chk("R6 done", int'(r_done), 1);
        chk("R6 reads", r_reads, 2);
        chk("R3 erase command", int'(wr_data), int'(ECMD));
        chk("R3 erase addr", int'(wr_addr), 'h800);
    endtask

    task automatic t_toggle;
        set_script({8'h3A, 8'h3A, 8'h3A, 8'h3A, 8'h3A, 8'h00, 8'h40, 8'h00});
        run_op(1'b0, 2'b10, 12'h0F0, 8'h3A, 8'd10, 1000, 1'b0, 0);
        chk("R7 toggle done", int'(r_done), 1);
        chk("R7 toggle reads", r_reads, 4);
    endtask

    task automatic t_confirm_ok;
        set_script({8'hA5, 8'hA5, 8'hA5, 8'hA5, 8'hA5, 8'hA5, 8'h85, 8'h25});
        run_op(1'b0, 2'b01, 12'h001, 8'hA5, 8'd10, 1000, 1'b0, 0);
        chk("R8 confirm done", int'(r_done), 1);
        chk("R8 confirm reads", r_reads, 4);
    endtask

    task automatic t_confirm_reject;
        set_script({8'hA5, 8'hA5, 8'hA5, 8'hA5, 8'hA5, 8'h85, 8'hA5, 8'h85});
        run_op(1'b0, 2'b01, 12'h002, 8'hA5, 8'd10, 1000, 1'b0, 0);
        chk("R8 reject error", int'(r_err), 1);
        chk("R8 reject reads", r_reads, 3);
    endtask

    task automatic t_poll_timeout_latched;
        set_script({8{8'h25}});
        run_op(1'b0, 2'b01, 12'h003, 8'hA5, 8'd3, 1000, 1'b1, 0);
        chk("R12 latched limit error", int'(r_err), 1);
        chk("R9 poll timeout reads", r_reads, 3);
        chk("R12 latched addr", int'(wr_addr), 'h003);
    endtask

    task automatic t_rsvd;
        run_op(1'b0, 2'b11, 12'h004, 8'h11, 8'd10, 1000, 1'b0, 0);
        chk("R10 reserved error", int'(r_err), 1);
        chk("R10 reserved latency", r_lat, 0);
        chk("R10 no write", wr_cnt, 0);
    endtask

    task automatic t_busy_ignore;
        set_script({8'hA5, 8'hA5, 8'hA5, 8'hA5, 8'hA5, 8'h25, 8'h25, 8'h25});
        run_op(1'b0, 2'b01, 12'h005, 8'hA5, 8'd10, 1000, 1'b0, 3);
        chk("R3 busy request ignored", wr_cnt, 1);
        chk("R3 op completes", int'(r_done), 1);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        set_script({8{8'hFF}});
        t_reset_idle();
        t_hw_ok();
        t_hw_timeout();
        t_data_prog();
        t_data_erase();
        t_toggle();
        t_confirm_ok();
        t_confirm_reject();
        t_poll_timeout_latched();
        t_rsvd();
        t_busy_ignore();
        t_reset_busy();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end
endmodule